// File: doc/BRIEF.md
# Raster Test Pattern Source

This block produces a complete raster video stream without any upstream video source, for bringing up a display path or a serial link. Each frame carries a vertical sync strobe, a horizontal sync strobe, a data-valid strobe and a 24-bit pixel word. Every strobe is described by its own set of counts in pixel clocks, so any frame format that fits the counter widths can be produced. While the data-valid strobe is high, the pixel word carries either a two-colour checkerboard or a grey ramp.

Software programs the block through a plain register write port (address, data, write strobe). Each write lands in a shadow copy. The running copy is reloaded from the shadow only at a frame boundary, or continuously while the block is idle. A 2-bit mode field starts and stops generation. After it is enabled, the first frame starts following a programmable start-up delay.

Top module: `vtpg_top`

## Requirements
- R1: Register map on `wr_addr`: 0 mode[1:0], 1 hsync high, 2 hsync low, 3 hsync pulse count, 4 data-valid high, 5 data-valid low, 6 data-valid pulse count, 7 data-valid delay, 8 vsync high, 9 vsync low, 10 start-up delay, 11 ramp step, 12 swap line count, 13 colour A run, 14 colour B run, 15 colour A, 16 colour B. Each field takes the low bits of `wr_data`. Other addresses are ignored. A write made while running has no effect on the outputs until the current frame ends.
- R2: Mode 0 (off) and mode 3 (reserved) keep `vsync`, `hsync`, `de` low and `pix` at zero.
- R3: When the mode changes from off to 1 or 2, `vsync` first goes high exactly 1 + start-up-delay clocks after the clock edge that accepts the write.
- R4: A frame lasts vsync-high + vsync-low clocks. `vsync` is high for the first vsync-high clocks of the frame.
- R5: From the frame start, `hsync` repeats a period of hsync-high clocks high followed by hsync-low clocks low, for hsync-count periods. After that it stays low until the frame ends.
- R6: `de` first rises data-valid-delay clocks after the frame start. It then repeats data-valid-high clocks high and data-valid-low clocks low, for data-valid-count pulses per frame.
- R7: `pix` is zero whenever `de` is low.
- R8: In mode 1, each `de` line begins with its start colour. The line then alternates runs of that colour and the other colour: colour A runs last colour-A-run pixels and colour B runs last colour-B-run pixels. The colour is output verbatim as the stored 24-bit value. A run count of 0 means 256.
- R9: In mode 1, lines start with colour A for the first swap-count `de` lines of each frame. The start colour then toggles after every further swap-count lines. A count of 0 means 256.
- R10: In mode 2, the value is 0 on the first pixel of each `de` line and grows by the ramp step per pixel, modulo 256. All three bytes of `pix` carry that value.
- R11: A mode change written while running (including to off) takes effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 24 | Register write data |
| vsync | output | 1 | Vertical sync strobe |
| hsync | output | 1 | Horizontal sync strobe |
| de | output | 1 | Data-valid strobe |
| pix | output | 24 | Pixel word, zero outside data-valid |

## Verification
The properties assume that every period the block uses is non-zero: vsync high plus low, hsync high plus low, and data-valid high plus low. With a zero period the wrap compare never matches and the frame length becomes the counter range. The stimulus therefore programs only small positive periods in which the hsync and data-valid trains fit inside one frame. It reprograms fields and modes mid-frame so that the hold-until-boundary rule is exercised. It also covers a zero colour-run count, a swap count of one and a ramp step that wraps modulo 256.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;

    localparam int LONG_W  = 24;
    localparam int SHORT_W = 16;
    localparam int BYTE_W  = 8;
    localparam int PIX_W   = 24;
    localparam int ADDR_W  = 5;
    localparam int MODE_W  = 2;
    localparam int CHANS   = PIX_W / BYTE_W;

    typedef logic [LONG_W-1:0]  long_t;
    typedef logic [SHORT_W-1:0] short_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [PIX_W-1:0]   pix_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF     = 2'd0,
        MODE_CHECKER = 2'd1,
        MODE_RAMP    = 2'd2,
        MODE_RSVD    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_RUN} tstate_e;

    typedef struct packed {
        mode_e  mode;
        long_t  vs_dly;
        long_t  vs_high;
        long_t  vs_low;
        short_t hs_high;
        short_t hs_low;
        short_t hs_cnt;
        long_t  de_dly;
        short_t de_high;
        short_t de_low;
        short_t de_cnt;
        pix_t   col_a;
        pix_t   col_b;
        byte_t  rpt_a;
        byte_t  rpt_b;
        byte_t  alt;
        byte_t  inc;
    } cfg_t;

    localparam logic [ADDR_W-1:0] A_MODE = 5'd0,  A_HSH  = 5'd1,  A_HSL  = 5'd2,
                                  A_HSC  = 5'd3,  A_DEH  = 5'd4,  A_DEL  = 5'd5,
                                  A_DEC  = 5'd6,  A_DED  = 5'd7,  A_VSH  = 5'd8,
                                  A_VSL  = 5'd9,  A_VSD  = 5'd10, A_INC  = 5'd11,
                                  A_ALT  = 5'd12, A_RPA  = 5'd13, A_RPB  = 5'd14,
                                  A_COLA = 5'd15, A_COLB = 5'd16;

    // Default raster: 1280 x 1080 active with standard blanking.
    localparam int H_ACT = 1280, H_FP = 88, H_SW = 44, H_BP = 148;
    localparam int V_ACT = 1080, V_FP = 4,  V_SW = 5,  V_BP = 36;
    localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;

    localparam cfg_t CFG_RESET = '{
        mode:    MODE_OFF,
        vs_dly:  long_t'(0),
        vs_high: long_t'(V_SW * H_TOT),
        vs_low:  long_t'((V_ACT + V_FP + V_BP) * H_TOT),
        hs_high: short_t'(H_SW),
        hs_low:  short_t'(H_ACT + H_FP + H_BP),
        hs_cnt:  short_t'(V_TOT),
        de_dly:  long_t'(H_TOT * (V_SW + V_BP) + H_SW + H_BP),
        de_high: short_t'(H_ACT),
        de_low:  short_t'(H_FP + H_SW + H_BP),
        de_cnt:  short_t'(V_ACT),
        col_a:   pix_t'(24'hFECC00),
        col_b:   pix_t'(24'h006AA7),
        rpt_a:   byte_t'(8'h3C),
        rpt_b:   byte_t'(8'h3C),
        alt:     byte_t'(8'h3C),
        inc:     byte_t'(8'h10)
    };

    function automatic logic mode_active(mode_e m);
        return (m == MODE_CHECKER) || (m == MODE_RAMP);
    endfunction

endpackage

// File: rtl/vtpg_regs.sv
module vtpg_regs
    import vtpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  long_t             wr_data,
    output cfg_t              shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= CFG_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE: shadow.mode    <= mode_e'(wr_data[MODE_W-1:0]);
                A_HSH:  shadow.hs_high <= wr_data[SHORT_W-1:0];
                A_HSL:  shadow.hs_low  <= wr_data[SHORT_W-1:0];
                A_HSC:  shadow.hs_cnt  <= wr_data[SHORT_W-1:0];
                A_DEH:  shadow.de_high <= wr_data[SHORT_W-1:0];
                A_DEL:  shadow.de_low  <= wr_data[SHORT_W-1:0];
                A_DEC:  shadow.de_cnt  <= wr_data[SHORT_W-1:0];
                A_DED:  shadow.de_dly  <= wr_data;
                A_VSH:  shadow.vs_high <= wr_data;
                A_VSL:  shadow.vs_low  <= wr_data;
                A_VSD:  shadow.vs_dly  <= wr_data;
                A_INC:  shadow.inc     <= wr_data[BYTE_W-1:0];
                A_ALT:  shadow.alt     <= wr_data[BYTE_W-1:0];
                A_RPA:  shadow.rpt_a   <= wr_data[BYTE_W-1:0];
                A_RPB:  shadow.rpt_b   <= wr_data[BYTE_W-1:0];
                A_COLA: shadow.col_a   <= wr_data[PIX_W-1:0];
                A_COLB: shadow.col_b   <= wr_data[PIX_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vtpg_timing.sv
module vtpg_timing
    import vtpg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t shadow,
    output cfg_t live,
    output logic run,
    output logic frame_wrap,
    output logic vsync,
    output logic hsync,
    output logic de,
    output logic de_last
);
    tstate_e state;
    long_t   dly_cnt, fpos;
    short_t  hcnt, hnum, dcnt, dnum;

    logic [LONG_W:0]  frame_m1;
    logic [SHORT_W:0] hper_m1, dper_m1, dhigh_m1;
    logic             last_pos, h_wrap, d_wrap, de_zone, h_more, d_more;

    always_comb begin
        frame_m1 = {1'b0, live.vs_high} + {1'b0, live.vs_low} - (LONG_W+1)'(1);
        hper_m1  = {1'b0, live.hs_high} + {1'b0, live.hs_low} - (SHORT_W+1)'(1);
        dper_m1  = {1'b0, live.de_high} + {1'b0, live.de_low} - (SHORT_W+1)'(1);
        dhigh_m1 = {1'b0, live.de_high} - (SHORT_W+1)'(1);
        last_pos = ({1'b0, fpos} == frame_m1);
        h_wrap   = ({1'b0, hcnt} == hper_m1);
        d_wrap   = ({1'b0, dcnt} == dper_m1);
        de_zone  = (fpos >= live.de_dly);
        h_more   = (hnum < live.hs_cnt);
        d_more   = (dnum < live.de_cnt);
        run        = (state == ST_RUN);
        frame_wrap = run && last_pos;
        vsync      = run && (fpos < live.vs_high);
        hsync      = run && h_more && (hcnt < live.hs_high);
        de         = run && de_zone && d_more && (dcnt < live.de_high);
        de_last    = de && ({1'b0, dcnt} == dhigh_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            live    <= CFG_RESET;
            dly_cnt <= '0;
            fpos    <= '0;
            hcnt    <= '0;
            hnum    <= '0;
            dcnt    <= '0;
            dnum    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    live <= shadow;
                    if (mode_active(shadow.mode)) begin
                        if (shadow.vs_dly == '0) begin
                            state <= ST_RUN;
                        end else begin
                            state   <= ST_DELAY;
                            dly_cnt <= long_t'(1);
                        end
                    end
                end
                ST_DELAY: begin
                    if (dly_cnt == live.vs_dly) state <= ST_RUN;
                    else dly_cnt <= dly_cnt + long_t'(1);
                end
                ST_RUN: begin
                    if (last_pos) begin
                        live <= shadow;
                        fpos <= '0;
                        hcnt <= '0;
                        hnum <= '0;
                        dcnt <= '0;
                        dnum <= '0;
                        if (!mode_active(shadow.mode)) state <= ST_IDLE;
                    end else begin
                        fpos <= fpos + long_t'(1);
                        if (h_more) begin
                            if (h_wrap) begin
                                hcnt <= '0;
                                hnum <= hnum + short_t'(1);
                            end else begin
                                hcnt <= hcnt + short_t'(1);
                            end
                        end
                        if (de_zone && d_more) begin
                            if (d_wrap) begin
                                dcnt <= '0;
                                dnum <= dnum + short_t'(1);
                            end else begin
                                dcnt <= dcnt + short_t'(1);
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vtpg_pixel.sv
module vtpg_pixel
    import vtpg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t live,
    input  logic run,
    input  logic frame_wrap,
    input  logic de,
    input  logic de_last,
    output pix_t pix
);
    logic  start_sel, csel;
    byte_t crun, altcnt, gval, cur_rpt;
    logic  run_end, alt_end, next_start;
    pix_t  ramp_pix;

    // The ramp value is replicated onto every colour channel.
    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        assign ramp_pix[c*BYTE_W +: BYTE_W] = gval;
    end

    always_comb begin
        cur_rpt    = csel ? live.rpt_b : live.rpt_a;
        run_end    = (crun == cur_rpt - byte_t'(1));
        alt_end    = (altcnt == live.alt - byte_t'(1));
        next_start = alt_end ? ~start_sel : start_sel;
        pix = '0;
        if (de) begin
            if (live.mode == MODE_CHECKER) pix = csel ? live.col_b : live.col_a;
            else if (live.mode == MODE_RAMP) pix = ramp_pix;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || frame_wrap) begin
            start_sel <= 1'b0;
            csel      <= 1'b0;
            crun      <= '0;
            altcnt    <= '0;
            gval      <= '0;
        end else if (de) begin
            if (de_last) begin
                crun      <= '0;
                gval      <= '0;
                altcnt    <= alt_end ? '0 : altcnt + byte_t'(1);
                start_sel <= next_start;
                csel      <= next_start;
            end else begin
                gval <= gval + live.inc;
                if (run_end) begin
                    crun <= '0;
                    csel <= ~csel;
                end else begin
                    crun <= crun + byte_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vtpg_top.sv
module vtpg_top
    import vtpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LONG_W-1:0] wr_data,
    output logic              vsync,
    output logic              hsync,
    output logic              de,
    output logic [PIX_W-1:0]  pix
);
    cfg_t shadow_cfg, live_cfg;
    logic run_s, frame_wrap_s, de_last_s;

    vtpg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .shadow  (shadow_cfg)
    );

    vtpg_timing u_timing (
        .clk        (clk),
        .rst        (rst),
        .shadow     (shadow_cfg),
        .live       (live_cfg),
        .run        (run_s),
        .frame_wrap (frame_wrap_s),
        .vsync      (vsync),
        .hsync      (hsync),
        .de         (de),
        .de_last    (de_last_s)
    );

    vtpg_pixel u_pixel (
        .clk        (clk),
        .rst        (rst),
        .live       (live_cfg),
        .run        (run_s),
        .frame_wrap (frame_wrap_s),
        .de         (de),
        .de_last    (de_last_s),
        .pix        (pix)
    );
endmodule

// File: rtl/vtpg_checker.sv
module vtpg_checker
    import vtpg_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic vsync,
    input logic hsync,
    input logic de,
    input pix_t pix,
    input logic run,
    input logic frame_wrap,
    input cfg_t live
);
    logic [SHORT_W:0] de_rises;
    logic             de_q;

    always_ff @(posedge clk) begin
        if (rst || !run || frame_wrap) begin
            de_rises <= '0;
        end else if (de && !de_q) begin
            de_rises <= de_rises + (SHORT_W+1)'(1);
        end
        de_q <= rst ? 1'b0 : de;
    end

    // R7: blanking outside the data-valid window
    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        !de |-> (pix == '0));

    // R2: nothing leaves the block while the raster is stopped
    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!vsync && !hsync && (pix == '0)));

    // R1: running settings only change at a frame boundary
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (run && !frame_wrap) |=> $stable(live));

    // R10: ramp is grey
    p_grey_r10: assert property (@(posedge clk) disable iff (rst)
        (de && live.mode == MODE_RAMP) |->
        (pix[23:16] == pix[15:8] && pix[15:8] == pix[7:0]));

    // R8: checkerboard only ever shows one of the two programmed colours
    p_two_col_r8: assert property (@(posedge clk) disable iff (rst)
        (de && live.mode == MODE_CHECKER) |->
        (pix == live.col_a || pix == live.col_b));

    // R6: no more data-valid pulses per frame than programmed
    p_de_count_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (de_rises <= {1'b0, live.de_cnt}));
endmodule

bind vtpg_top vtpg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .vsync      (vsync),
    .hsync      (hsync),
    .de         (de),
    .pix        (pix),
    .run        (run_s),
    .frame_wrap (frame_wrap_s),
    .live       (live_cfg)
);

// File: tb/vtpg_top_tb.sv
module vtpg_top_tb;

    localparam int K_MODE = 0,  K_HSH = 1,  K_HSL = 2,  K_HSC = 3,  K_DEH = 4,
                   K_DEL  = 5,  K_DEC = 6,  K_DED = 7,  K_VSH = 8,  K_VSL = 9,
                   K_VSD  = 10, K_INC = 11, K_ALT = 12, K_RPA = 13, K_RPB = 14,
                   K_COLA = 15, K_COLB = 16, NREG = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        vsync, hsync, de;
    logic [23:0] pix;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R2 reset";

    int sh[NREG];
    int lv[NREG];
    int mst = 0;
    int dc = 0;
    int p = 0;

    always #5 clk = ~clk;

    vtpg_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vsync(vsync), .hsync(hsync), .de(de), .pix(pix)
    );

    function automatic int nz(int v);
        return (v == 0) ? 256 : v;
    endfunction

    function automatic int field_mask(int a);
        if (a == K_MODE) return 3;
        if (a == K_VSH || a == K_VSL || a == K_VSD || a == K_DED ||
            a == K_COLA || a == K_COLB) return 32'hFFFFFF;
        if (a >= K_INC) return 32'hFF;
        return 32'hFFFF;
    endfunction

    function automatic bit enabled(int m);
        return (m == 1) || (m == 2);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        sh[K_MODE] = 0;
        sh[K_VSD] = 0;        sh[K_VSH] = 5 * 1560;  sh[K_VSL] = 1120 * 1560;
        sh[K_HSH] = 44;       sh[K_HSL] = 1516;      sh[K_HSC] = 1125;
        sh[K_DED] = 1560 * 41 + 192;
        sh[K_DEH] = 1280;     sh[K_DEL] = 280;       sh[K_DEC] = 1080;
        sh[K_COLA] = 'hFECC00; sh[K_COLB] = 'h006AA7;
        sh[K_RPA] = 'h3C;     sh[K_RPB] = 'h3C;      sh[K_ALT] = 'h3C;  sh[K_INC] = 'h10;
        lv = sh;
        mst = 0; dc = 0; p = 0;
    endtask

    initial model_reset();

    // Reference: outputs from the absolute frame position, then one clock of state.
    always @(negedge clk) begin : mdl
        int ev, eh, ed, epix, hp, dp, q, k, r, ra, rb, m, st, g;
        string ptag;
        ev = 0; eh = 0; ed = 0; epix = 0; k = 0; ptag = "R7";
        if (!done) begin
            if (mst == 2) begin
                ev = (p < lv[K_VSH]);
                hp = lv[K_HSH] + lv[K_HSL];
                eh = ((p / hp) < lv[K_HSC]) && ((p % hp) < lv[K_HSH]);
                if (p >= lv[K_DED]) begin
                    q  = p - lv[K_DED];
                    dp = lv[K_DEH] + lv[K_DEL];
                    k  = q / dp;
                    r  = q % dp;
                    ed = (k < lv[K_DEC]) && (r < lv[K_DEH]);
                end
                if (ed && lv[K_MODE] == 1) begin
                    ptag = (k >= nz(lv[K_ALT])) ? "R9" : "R8";
                    st = (k / nz(lv[K_ALT])) % 2;
                    ra = nz(lv[K_RPA]);
                    rb = nz(lv[K_RPB]);
                    m  = r % (ra + rb);
                    if (st == 0) epix = (m < ra) ? lv[K_COLA] : lv[K_COLB];
                    else         epix = (m < rb) ? lv[K_COLB] : lv[K_COLA];
                end else if (ed && lv[K_MODE] == 2) begin
                    ptag = "R10";
                    g = (r * lv[K_INC]) % 256;
                    epix = g * 65536 + g * 256 + g;
                end
            end else begin
                ptag = "R2";
            end
            chk((mst == 2) ? "R4" : "R2", int'(vsync), ev);
            chk((mst == 2) ? "R5" : "R2", int'(hsync), eh);
            chk((mst == 2) ? "R6" : "R2", int'(de), ed);
            chk(ptag, int'(pix), epix);

            if (rst) begin
                model_reset();
            end else begin
                case (mst)
                    0: begin
                        lv = sh;
                        if (enabled(sh[K_MODE])) begin
                            if (sh[K_VSD] == 0) begin mst = 2; p = 0; end
                            else begin mst = 1; dc = 1; end
                        end
                    end
                    1: begin
                        if (dc == lv[K_VSD]) begin mst = 2; p = 0; end
                        else dc++;
                    end
                    default: begin
                        if (p == lv[K_VSH] + lv[K_VSL] - 1) begin
                            lv = sh;
                            p = 0;
                            if (!enabled(sh[K_MODE])) mst = 0;
                        end else begin
                            p++;
                        end
                    end
                endcase
                if (wr_en && int'(wr_addr) < NREG)
                    sh[wr_addr] = int'(wr_data) & field_mask(int'(wr_addr));
            end
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d[23:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog [%s] run did not complete", phase);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        idle(5);

        // R2: reserved mode keeps everything quiet
        phase = "R2 reserved mode";
        wr(K_MODE, 3);
        wr(28, 1);            // unmapped address, ignored (R1)
        idle(10);

        // R3: program a small raster, then start with a 3-clock delay
        phase = "R3 start-up";
        wr(K_VSD, 3);  wr(K_VSH, 6);  wr(K_VSL, 60);
        wr(K_HSH, 2);  wr(K_HSL, 9);  wr(K_HSC, 6);
        wr(K_DED, 14); wr(K_DEH, 6);  wr(K_DEL, 5);  wr(K_DEC, 4);
        wr(K_COLA, 'hFECC00); wr(K_COLB, 'h006AA7);
        wr(K_RPA, 2);  wr(K_RPB, 3);  wr(K_ALT, 2);  wr(K_INC, 'h10);
        wr(K_MODE, 1);
        idle(210);

        // R1: mid-frame writes wait for the frame boundary
        phase = "R1 shadow";
        idle(20);
        wr(K_COLA, 'h123456);
        wr(K_RPA, 1);
        idle(150);

        // R11 / R10: switch to the ramp mid-frame with a wrapping step
        phase = "R11 mode change";
        wr(K_MODE, 2);
        wr(K_INC, 'h70);
        idle(150);

        // R5 / R6 / R8 / R9: different pulse counts, zero run count, swap every line
        phase = "R5 R6 R8 R9 variant";
        wr(K_HSC, 3);  wr(K_DEC, 2);  wr(K_DEH, 7);
        wr(K_MODE, 1); wr(K_RPA, 0);  wr(K_ALT, 1);
        idle(150);
        wr(K_RPA, 2);
        idle(150);

        // R2 / R11: turn off while running
        phase = "R2 disable";
        wr(K_MODE, 0);
        idle(150);

        finish_run();
    end

endmodule